// File: doc/BRIEF.md
# Double-Buffered Four-Output PWM Generator

This block produces a pulse-width modulated waveform from a prescaled 8-bit timer. The timer is extended by two fractional bits to form a 10-bit time base. A cycle starts when the timer wraps past its period value. At that wrap the modulated signal goes active unless the duty is zero, and it goes inactive again when the 10-bit time base reaches the duty value. The signal is then steered onto four pins, A to D, by one of four output configurations. A polarity bit per pin pair makes those pins active-high or active-low. In the half-bridge configuration, a dead-band delay postpones the rising edge of each of the two complementary pins.

Software programs the block through a byte-wide write port with four addresses. Every value except the enable bit is written into a shadow copy. Period, duty, configuration, prescaler and polarity move from the shadow copies into the working set only at a cycle wrap. The dead-band count moves at the first duty match or cycle wrap that follows the write. After enabling, the block spends four clocks in an arming state before the first cycle begins. Control is held by three named states: IDLE (disabled, pins inactive), ARM (enabled, waiting) and RUN (generating). Their transitions are: IDLE to ARM when the enable bit is set; ARM to RUN after four clocks in ARM; ARM to IDLE and RUN to IDLE when the enable bit is cleared.

Top module: `pwm4_gen`

## Requirements
- R1: The cycle length is (P+1)*4*S clocks. P is the byte at address 0. S is 1, 4 or 16 for prescale code 00, 01 or 1x, held in bits [3:2] of address 2.
- R2: The duty D is 10 bits: bits [9:2] come from address 1 and bits [1:0] from bits [5:4] of address 2. For 0 < D < (P+1)*4, the modulated signal is active for D*S clocks of each cycle.
- R3: With D = 0 the modulated signal never goes active. With D >= (P+1)*4 it is active for the whole cycle.
- R4: A write to address 0, 1 or 2 has no effect on the cycle in progress. It takes effect from the next cycle wrap.
- R5: After the write that sets the enable bit (bit 7 of address 3), the pins stay inactive for five clock edges. In configuration 00 with D > 0, pin A is first active after the fifth rising edge that follows the write's committing edge.
- R6: Bits [7:6] of address 2 select the configuration. 00: A modulated, B/C/D inactive. 01: A held active, D modulated, B/C inactive. 10: half bridge on A and B, C/D inactive. 11: C held active, B modulated, A/D inactive.
- R7: Bit 0 of address 2 makes pins A and C active-low. Bit 1 makes pins B and D active-low. A pin's level is its active state XOR its polarity bit.
- R8: In the half bridge, A follows the modulated signal and B its complement. Each rises dead-band+1 clocks after its source rises and falls one clock after its source falls, so A is active D*S minus dead-band clocks per cycle and B is active the rest of the cycle minus dead-band clocks. A and B are never active together.
- R9: The dead-band count in bits [6:0] of address 3 takes effect at the first duty match or cycle wrap after it is written.
- R10: Clearing the enable bit takes the block to IDLE on the next edge after the write commits. From then on all pins sit at their inactive level.
- R11: During and after reset all four pins are low and the block is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 period, 1 duty high, 2 control, 3 enable/dead band) |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 4 | Pin levels, bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D |

## Verification
Each kind of internal fault has its own signature at the pins:
- A timer that clears one count early or late changes the rising-edge spacing on pin A within one cycle.
- A duty comparator that loads at the wrong time moves the falling edge of the very cycle in which the write happened.
- A dead-band register that loads only at the wrap shows up three clocks early on pin B, still in the current cycle.
- Bad steering or polarity changes the active-clock count on the wrong pin over a two-cycle window.
- A wrong arming count shifts the first active sample of pin A by whole clocks.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int TMR_W  = 8;
    localparam int FRAC_W = 2;
    localparam int TB_W   = TMR_W + FRAC_W;
    localparam int DB_W   = 7;
    localparam int PS_W   = 4;
    localparam int ADDR_W = 2;
    localparam int LEGS   = 2;
    localparam int PINS   = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        STEER_SINGLE = 2'b00,
        STEER_FWD    = 2'b01,
        STEER_HALF   = 2'b10,
        STEER_REV    = 2'b11
    } steer_e;

    localparam logic [ADDR_W-1:0] REG_PERIOD = 2'd0;
    localparam logic [ADDR_W-1:0] REG_DUTY   = 2'd1;
    localparam logic [ADDR_W-1:0] REG_CTRL   = 2'd2;
    localparam logic [ADDR_W-1:0] REG_DEAD   = 2'd3;

    typedef struct packed {
        logic [TMR_W-1:0] period;
        logic [TB_W-1:0]  duty;
        steer_e           steer;
        logic [1:0]       presc;
        logic [1:0]       pol;
    } cyc_cfg_t;

    // terminal value of the prescale counter for each prescale code
    function automatic logic [PS_W-1:0] presc_last(input logic [1:0] code);
        logic [PS_W-1:0] r;
        case (code)
            2'b00:   r = PS_W'(0);
            2'b01:   r = PS_W'(3);
            default: r = PS_W'(15);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
    import pwm4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TMR_W-1:0]  wr_data,
    output cyc_cfg_t          shadow,
    output logic [DB_W-1:0]   dead_sh,
    output logic              enable
);

    // shadow copies; nothing here reaches the pins until the core loads it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow  <= cyc_cfg_t'('0);
            dead_sh <= '0;
            enable  <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_PERIOD: shadow.period <= wr_data;
                REG_DUTY:   shadow.duty[TB_W-1:FRAC_W] <= wr_data;
                REG_CTRL: begin
                    shadow.steer <= steer_e'(wr_data[7:6]);
                    shadow.duty[FRAC_W-1:0] <= wr_data[5:4];
                    shadow.presc <= wr_data[3:2];
                    shadow.pol   <= wr_data[1:0];
                end
                default: begin
                    enable  <= wr_data[7];
                    dead_sh <= wr_data[DB_W-1:0];
                end
            endcase
        end
    end

endmodule

// File: rtl/pwm4_core.sv
module pwm4_core
    import pwm4_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  cyc_cfg_t        shadow,
    input  logic [DB_W-1:0] dead_sh,
    output logic            run,
    output logic            raw,
    output cyc_cfg_t        act_cfg,
    output logic [DB_W-1:0] act_dead
);

    localparam int ARM_W = 2;
    localparam logic [ARM_W-1:0]  ARM_LAST = '1;
    localparam logic [FRAC_W-1:0] FRAC_TOP = '1;

    run_state_e       state, state_nx;
    logic [ARM_W-1:0] arm_cnt;
    logic [PS_W-1:0]  pre_cnt;
    logic [TB_W-1:0]  tb, tb_inc;
    logic             tick, wrap, load_now, duty_hit;

    assign tb_inc   = tb + TB_W'(1);
    assign tick     = (pre_cnt == presc_last(act_cfg.presc));
    assign wrap     = tick && (tb == {act_cfg.period, FRAC_TOP});
    assign load_now = enable && ((state == ST_ARM && arm_cnt == ARM_LAST) ||
                                 (state == ST_RUN && wrap));
    assign duty_hit = (state == ST_RUN) && tick && !wrap && (tb_inc == act_cfg.duty);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: IDLE->ARM on enable, ARM->RUN after four clocks,
    // ARM/RUN->IDLE when enable drops
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (enable) state_nx = ST_ARM;
            ST_ARM: begin
                if (!enable)                  state_nx = ST_IDLE;
                else if (arm_cnt == ARM_LAST) state_nx = ST_RUN;
            end
            ST_RUN:  if (!enable) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        run = (state == ST_RUN);
    end

    // time base, working set and set/reset of the modulated signal
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_cnt  <= '0;
            pre_cnt  <= '0;
            tb       <= '0;
            raw      <= 1'b0;
            act_cfg  <= cyc_cfg_t'('0);
            act_dead <= '0;
        end else begin
            arm_cnt <= (state == ST_ARM) ? arm_cnt + ARM_W'(1) : '0;
            if (load_now) begin
                act_cfg  <= shadow;
                act_dead <= dead_sh;
                tb       <= '0;
                pre_cnt  <= '0;
                raw      <= (shadow.duty != '0);
            end else if (state == ST_RUN) begin
                if (tick) begin
                    pre_cnt <= '0;
                    tb      <= tb_inc;
                    if (duty_hit) raw <= 1'b0;
                end else begin
                    pre_cnt <= pre_cnt + PS_W'(1);
                end
                if (duty_hit) act_dead <= dead_sh;
            end else begin
                pre_cnt <= '0;
                tb      <= '0;
                raw     <= 1'b0;
            end
        end
    end

    a_r1_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && wrap && enable) |=> (tb == '0 && run));

    a_r2_fall_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        duty_hit |=> !raw);

    a_r3_zero_duty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_cfg.duty == '0) |-> !raw);

    a_r4_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !wrap) |=> $stable(act_cfg));

    a_r5_arm_span: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> $past(state == ST_ARM, 4));

    a_r10_drop_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && state != ST_IDLE) |=> (state == ST_IDLE));

endmodule

// File: rtl/pwm4_dead_leg.sv
module pwm4_dead_leg
    import pwm4_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_act,
    input  logic [DB_W-1:0] dead,
    output logic            out_act
);

    logic [DB_W-1:0] cnt;
    logic            out_nx;

    // rise waits until cnt reaches the dead count, fall follows at once
    assign out_nx = in_act && (out_act || cnt == dead);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            out_act <= 1'b0;
        end else begin
            out_act <= out_nx;
            cnt     <= (in_act && !out_nx) ? cnt + DB_W'(1) : '0;
        end
    end

    a_r8_rise_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_act) |-> $past(in_act));

    a_r8_fall_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_act |=> !out_act);

endmodule

// File: rtl/pwm4_steer.sv
module pwm4_steer
    import pwm4_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  steer_e          steer,
    input  logic [1:0]      pol,
    input  logic            raw,
    input  logic [LEGS-1:0] leg_out,
    output logic [PINS-1:0] pins
);

    logic [PINS-1:0] act;

    always_comb begin
        act = '0;
        unique case (steer)
            STEER_SINGLE: act[0] = raw;
            STEER_FWD: begin
                act[0] = 1'b1;
                act[3] = raw;
            end
            STEER_HALF: begin
                act[0] = leg_out[0];
                act[1] = leg_out[1];
            end
            STEER_REV: begin
                act[2] = 1'b1;
                act[1] = raw;
            end
            default: act = '0;
        endcase
        if (!run) act = '0;
    end

    // even pins (A, C) use pol[0], odd pins (B, D) use pol[1]
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign pins[p] = act[p] ^ pol[p % 2];
    end

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && steer == STEER_HALF) |-> !(leg_out[0] && leg_out[1]));

    a_r10_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (act == '0));

endmodule

// File: rtl/pwm4_gen.sv
module pwm4_gen
    import pwm4_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic [3:0]  pwm_out
);

    cyc_cfg_t        shadow, act_cfg;
    logic [DB_W-1:0] dead_sh, act_dead;
    logic            enable, run, raw;
    logic [LEGS-1:0] leg_in, leg_out;

    pwm4_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .shadow  (shadow),
        .dead_sh (dead_sh),
        .enable  (enable)
    );

    pwm4_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .shadow   (shadow),
        .dead_sh  (dead_sh),
        .run      (run),
        .raw      (raw),
        .act_cfg  (act_cfg),
        .act_dead (act_dead)
    );

    // leg 0 follows the modulated signal, leg 1 its complement
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        assign leg_in[g] = run && (raw ^ (g % 2 == 1));
        pwm4_dead_leg u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_act  (leg_in[g]),
            .dead    (act_dead),
            .out_act (leg_out[g])
        );
    end

    pwm4_steer u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .steer   (act_cfg.steer),
        .pol     (act_cfg.pol),
        .raw     (raw),
        .leg_out (leg_out),
        .pins    (pwm_out)
    );

endmodule

// File: tb/pwm4_gen_tb_top.sv
module pwm4_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwm4_gen dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    typedef struct packed {
        int pr; int duty; int mode; int pol; int ps; int db;
        int ep; int ea; int eb; int ec; int ed;
    } vec_t;

    localparam int NV = 9;
    // pr, duty, mode, pol, ps, db | clocks per cycle, active clocks on A, B, C, D
    localparam vec_t VEC [NV] = '{
        '{2, 5,  0, 0, 0, 0,  12,  5,  0,  0, 0},
        '{9, 17, 0, 1, 1, 0, 160, 68,  0,  0, 0},
        '{3, 0,  0, 0, 0, 0,  16,  0,  0,  0, 0},
        '{3, 20, 0, 0, 0, 0,  16, 16,  0,  0, 0},
        '{4, 8,  1, 0, 0, 0,  20, 20,  0,  0, 8},
        '{4, 8,  3, 3, 0, 0,  20,  0,  8, 20, 0},
        '{5, 10, 2, 0, 0, 3,  24,  7, 11,  0, 0},
        '{5, 10, 2, 3, 0, 0,  24, 10, 14,  0, 0},
        '{1, 3,  0, 0, 2, 0, 128, 48,  0,  0, 0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int lvl(input int p, input int pol);
        return int'(pwm_out[p] ^ ((p % 2 == 0) ? pol[0] : pol[1]));
    endfunction

    initial begin
        #(10 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic prv;
        int   pos;
        repeat (3) @(negedge clk);
        check("R11 pins in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 pins after reset", int'(pwm_out), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int cnt [4];
            int rises, both;
            logic pa;
            string tag;
            v = VEC[i];
            wr(2'd3, 8'h00);
            wr(2'd0, 8'(v.pr));
            wr(2'd1, 8'(v.duty >> 2));
            wr(2'd2, {v.mode[1:0], v.duty[1:0], v.ps[1:0], v.pol[1:0]});
            wr(2'd3, 8'h80 | 8'(v.db));
            repeat (2 * v.ep + 12) @(negedge clk);
            for (int p = 0; p < 4; p++) cnt[p] = 0;
            rises = 0; both = 0;
            pa = 1'(lvl(0, v.pol));
            for (int k = 0; k < 2 * v.ep; k++) begin
                @(negedge clk);
                for (int p = 0; p < 4; p++) cnt[p] += lvl(p, v.pol);
                if (lvl(0, v.pol) == 1 && !pa) rises++;
                if (lvl(0, v.pol) == 1 && lvl(1, v.pol) == 1) both++;
                pa = 1'(lvl(0, v.pol));
            end
            if (v.pol != 0)                      tag = "R7";
            else if (v.mode == 2)                tag = "R8";
            else if (v.mode != 0)                tag = "R6";
            else if (v.ea == 0 || v.ea == v.ep)  tag = "R3";
            else                                 tag = "R2";
            check({tag, " pin A"}, cnt[0], 2 * v.ea);
            check({tag, " pin B"}, cnt[1], 2 * v.eb);
            check({tag, " pin C"}, cnt[2], 2 * v.ec);
            check({tag, " pin D"}, cnt[3], 2 * v.ed);
            if (v.ea > 0 && v.ea < v.ep)
                check("R1 cycle length via A rises", rises, 2);
            if (v.mode == 2)
                check("R8 A and B overlap", both, 0);
        end

        // R5: arming delay
        wr(2'd3, 8'h00);
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd1);
        wr(2'd2, 8'h10);
        repeat (3) @(negedge clk);
        wr(2'd3, 8'h80);
        pos = 0;
        for (int k = 0; k < 5; k++) begin
            pos += int'(pwm_out[0]);
            @(negedge clk);
        end
        check("R5 A quiet during arming", pos, 0);
        check("R5 A active after fifth edge", int'(pwm_out[0]), 1);

        // R4: duty write inside a cycle waits for the wrap (duty 5 -> 9)
        prv = pwm_out[0];
        forever begin
            @(negedge clk);
            if (pwm_out[0] && !prv) break;
            prv = pwm_out[0];
        end
        wr(2'd1, 8'd2);
        repeat (4) @(negedge clk);
        check("R4 old duty kept in current cycle", int'(pwm_out[0]), 0);
        repeat (6) @(negedge clk);
        check("R4 next cycle starts", int'(pwm_out[0]), 1);
        repeat (6) @(negedge clk);
        check("R4 new duty active late in cycle", int'(pwm_out[0]), 1);
        repeat (3) @(negedge clk);
        check("R4 new duty ends", int'(pwm_out[0]), 0);

        // R9: dead band loads at the duty match
        wr(2'd3, 8'h00);
        wr(2'd0, 8'd5);
        wr(2'd1, 8'd2);
        wr(2'd2, 8'hA0);
        wr(2'd3, 8'h80);
        repeat (60) @(negedge clk);
        prv = pwm_out[1];
        forever begin
            @(negedge clk);
            if (!pwm_out[1] && prv) break;
            prv = pwm_out[1];
        end
        wr(2'd3, 8'h83);
        repeat (10) @(negedge clk);
        check("R9 B held by new dead band", int'(pwm_out[1]), 0);
        @(negedge clk);
        check("R9 B rises after new dead band", int'(pwm_out[1]), 1);

        // R10: disable
        wr(2'd3, 8'h00);
        @(negedge clk);
        check("R10 pins inactive after disable", int'(pwm_out), 0);
        repeat (30) @(negedge clk);
        check("R10 pins stay inactive", int'(pwm_out), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule